// File: doc/BRIEF.md
# Masked Edge/Level Interrupt Combiner

This block gathers up to 32 interrupt request lines from peripherals and DMA channels and presents them to the processor as a single latched interrupt output. Each source has three pieces of state: a captured event bit, a level bit that mirrors the line, and an enable bit. Software reaches this state through four 32-bit registers on a small word-select bus. The bus carries each word with its four bytes reversed relative to the internal value.

Event capture has two modes, chosen by the top bit of the enable register. In edge mode a source records an event only when its line rises. A falling line removes that source's event. In any-change mode every transition of a line records an event. The processor interrupt is raised when a line update leaves at least one event pending. It is dropped only after a clear write that leaves no event pending.

Top module: `irq_aggregator`

## Requirements
- R1: Word select 0 is the enable register (read/write), 1 the event register (read only), 2 the level register (read only), 3 the clear register (write only). Bus data is the internal word with byte order reversed: bus bits 7:0 carry internal bits 31:24, and so on. Reads are combinational.
- R2: Reading select 3 returns zero. Writes to select 1 or 2 change no state.
- R3: Each clock, every level bit takes the value its input line had at that edge.
- R4: When enable bit 31 is 1 (any-change mode), every line that differs from its stored level sets its event bit.
- R5: When enable bit 31 is 0 (edge mode), a line going 0 to 1 sets its event bit and a line going 1 to 0 clears it. Event bits of unchanged lines keep their value.
- R6: In any cycle where at least one line changes, the resulting event word is ANDed with the enable value held before that cycle's write.
- R7: A clear write with enable bit 31 set and written bit 31 set zeroes all events. Otherwise it clears each event whose written bit is 1 among bits 30..0, and written bit 31 has no effect.
- R8: cpu_irq rises on the edge that processes a line change if the resulting event word is nonzero. Once high it stays high until released.
- R9: cpu_irq falls only on a clear write that leaves the event word zero. A clear leaving any event pending keeps it high.
- R10: When a clear write and a line change meet in one cycle, the clear is applied first and the line update second, so the new event survives.
- R11: Reset (rst_n low, asynchronous) zeroes enables, events and levels and holds cpu_irq low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lines | input | 32 | Interrupt request lines, one per source |
| bus_sel | input | 2 | Register word select |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 32 | Write data, byte-reversed |
| bus_rdata | output | 32 | Read data of the selected register, byte-reversed |
| cpu_irq | output | 1 | Latched processor interrupt |

## Verification
A wrong event bit shows on the event register read in the cycle after the offending edge. It also shows on cpu_irq as a missed rise or a release that comes too early or never comes. A bad level bit appears in the level read one cycle after the line changes. It also corrupts the next transition's classification, so it shows a second time in the event word. Because every register and the interrupt are compared after every clock, a divergence is caught within one cycle of the edge that caused it.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_EVENTS = 2'd1,
        SEL_LEVELS = 2'd2,
        SEL_CLEAR  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/irqagg_regport.sv
module irqagg_regport
    import irqagg_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_sel,
    input  logic             bus_wr,
    input  logic [NSRC-1:0]  bus_wdata,
    input  logic [NSRC-1:0]  events_q,
    input  logic [NSRC-1:0]  levels_q,
    input  logic [NSRC-1:0]  enable_q,
    output logic             enable_wr,
    output logic             clear_wr,
    output logic [NSRC-1:0]  wval,
    output logic [NSRC-1:0]  bus_rdata
);
    localparam int NBYTES = NSRC / 8;

    logic [NSRC-1:0] rsel_val;

    always_comb begin
        enable_wr = bus_wr && (bus_sel == SEL_ENABLE);
        clear_wr  = bus_wr && (bus_sel == SEL_CLEAR);
        case (reg_sel_e'(bus_sel))
            SEL_ENABLE: rsel_val = enable_q;
            SEL_EVENTS: rsel_val = events_q;
            SEL_LEVELS: rsel_val = levels_q;
            default:    rsel_val = '0;
        endcase
    end

    for (genvar g = 0; g < NBYTES; g++) begin : g_swap
        assign wval[g*8 +: 8]      = bus_wdata[(NBYTES-1-g)*8 +: 8];
        assign bus_rdata[g*8 +: 8] = rsel_val[(NBYTES-1-g)*8 +: 8];
    end

    AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel == SEL_CLEAR) |-> (bus_rdata == '0)); // R2

endmodule

// File: rtl/irqagg_capture.sv
module irqagg_capture #(
    parameter int NSRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_lines,
    input  logic             enable_wr,
    input  logic             clear_wr,
    input  logic [NSRC-1:0]  wval,
    output logic [NSRC-1:0]  events_q,
    output logic [NSRC-1:0]  levels_q,
    output logic [NSRC-1:0]  enable_q,
    output logic [NSRC-1:0]  events_nx,
    output logic             line_upd
);
    localparam int              MODE_BIT  = NSRC - 1;
    localparam logic [NSRC-1:0] CLR_FIELD = {1'b0, {(NSRC-1){1'b1}}};

    typedef struct packed {
        logic [NSRC-1:0] events;
        logic [NSRC-1:0] levels;
        logic [NSRC-1:0] enable;
    } cap_state_t;

    cap_state_t st_d, st_q;
    logic [NSRC-1:0] changed;
    logic [NSRC-1:0] ev_work;

    always_comb begin
        ev_work = st_q.events;
        if (clear_wr) begin
            if (st_q.enable[MODE_BIT] && wval[MODE_BIT]) begin
                ev_work = '0;
            end else begin
                ev_work = ev_work & ~(wval & CLR_FIELD);
            end
        end

        changed  = src_lines ^ st_q.levels;
        line_upd = |changed;
        if (st_q.enable[MODE_BIT]) begin
            ev_work = ev_work | changed;
        end else begin
            ev_work = (ev_work | (changed & src_lines)) & ~(changed & ~src_lines);
        end
        if (line_upd) begin
            ev_work = ev_work & st_q.enable;
        end

        st_d.events = ev_work;
        st_d.levels = src_lines;
        st_d.enable = enable_wr ? wval : st_q.enable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign events_q  = st_q.events;
    assign levels_q  = st_q.levels;
    assign enable_q  = st_q.enable;
    assign events_nx = st_d.events;

    AST_LEVELS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (levels_q == $past(src_lines))); // R3

    AST_ENABLE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(line_upd)) |-> ((events_q & ~$past(enable_q)) == '0)); // R6

    AST_FULL_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(clear_wr && enable_q[MODE_BIT] && wval[MODE_BIT] && !line_upd))
        |-> (events_q == '0)); // R7

endmodule

// File: rtl/irqagg_cpu_latch.sv
module irqagg_cpu_latch #(
    parameter int NSRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_upd,
    input  logic             clear_wr,
    input  logic [NSRC-1:0]  events_nx,
    input  logic [NSRC-1:0]  events_q,
    output logic             irq_q
);
    logic irq_d;

    always_comb begin
        irq_d = irq_q;
        if (line_upd && (|events_nx)) begin
            irq_d = 1'b1;
        end else if (clear_wr && (events_nx == '0)) begin
            irq_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq_d;
        end
    end

    AST_PENDING_HOLDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (|events_q) |-> irq_q); // R8

    AST_NO_SPURIOUS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(irq_q)) |-> ($past(clear_wr) && (events_q == '0))); // R9

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
    parameter int NSRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_lines,
    input  logic [1:0]       bus_sel,
    input  logic             bus_wr,
    input  logic [NSRC-1:0]  bus_wdata,
    output logic [NSRC-1:0]  bus_rdata,
    output logic             cpu_irq
);
    logic             enable_wr;
    logic             clear_wr;
    logic [NSRC-1:0]  wval;
    logic [NSRC-1:0]  events_q;
    logic [NSRC-1:0]  levels_q;
    logic [NSRC-1:0]  enable_q;
    logic [NSRC-1:0]  events_nx;
    logic             line_upd;

    irqagg_regport #(.NSRC(NSRC)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .events_q  (events_q),
        .levels_q  (levels_q),
        .enable_q  (enable_q),
        .enable_wr (enable_wr),
        .clear_wr  (clear_wr),
        .wval      (wval),
        .bus_rdata (bus_rdata)
    );

    irqagg_capture #(.NSRC(NSRC)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_lines (src_lines),
        .enable_wr (enable_wr),
        .clear_wr  (clear_wr),
        .wval      (wval),
        .events_q  (events_q),
        .levels_q  (levels_q),
        .enable_q  (enable_q),
        .events_nx (events_nx),
        .line_upd  (line_upd)
    );

    irqagg_cpu_latch #(.NSRC(NSRC)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_upd  (line_upd),
        .clear_wr  (clear_wr),
        .events_nx (events_nx),
        .events_q  (events_q),
        .irq_q     (cpu_irq)
    );

endmodule

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;
    localparam int CLK_PERIOD = 10;
    localparam int SWEEP_STEPS = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_lines = '0;
    logic [1:0]  bus_sel = 2'd0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cpu_irq;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    logic [31:0] m_ev = '0, m_lv = '0, m_en = '0;
    logic        m_irq = 1'b0;

    irq_aggregator u0 (
        .clk(clk), .rst_n(rst_n), .src_lines(src_lines), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] swap(input logic [31:0] x);
        return {x[7:0], x[15:8], x[23:16], x[31:24]};
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic read_reg(input logic [1:0] sel, output logic [31:0] val);
        bus_sel = sel;
        #1;
        val = swap(bus_rdata);
    endtask

    task automatic check_all(input string tag);
        logic [31:0] v;
        read_reg(2'd0, v); check(tag, "enable(R1)", v, m_en);
        read_reg(2'd1, v); check(tag, "events", v, m_ev);
        read_reg(2'd2, v); check(tag, "levels(R3)", v, m_lv);
        read_reg(2'd3, v); check(tag, "clear read(R2)", v, 32'h0);
        check(tag, "cpu_irq", {31'b0, cpu_irq}, {31'b0, m_irq});
    endtask

    // one clock with given stimulus; starts and ends at a falling edge
    task automatic step(input logic [31:0] ln, input logic wr, input logic [1:0] sel,
                        input logic [31:0] val, input string tag);
        logic [31:0] ev, chg;
        logic clr;
        src_lines = ln;
        bus_wr    = wr;
        bus_sel   = sel;
        bus_wdata = swap(val);
        @(posedge clk);
        clr = wr && (sel == 2'd3);
        ev  = m_ev;
        if (clr) begin
            if (m_en[31] && val[31]) ev = '0;
            else ev = ev & ~(val & 32'h7FFF_FFFF);
        end
        chg = ln ^ m_lv;
        if (m_en[31]) ev = ev | chg;
        else ev = (ev | (chg & ln)) & ~(chg & ~ln);
        if (chg != 0) ev = ev & m_en;
        if ((chg != 0) && (ev != 0)) m_irq = 1'b1;
        else if (clr && (ev == 0)) m_irq = 1'b0;
        m_ev = ev;
        m_lv = ln;
        if (wr && sel == 2'd0) m_en = val;
        @(negedge clk);
        bus_wr = 1'b0;
        check_all(tag);
    endtask

    initial begin : watchdog
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [31:0] lfsr;
        logic [31:0] ln;
        repeat (3) @(negedge clk);
        check_all("R11 reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R1: enable write/readback, edge mode
        step(32'h0, 1'b1, 2'd0, 32'h7FFF_FFFF, "R1");
        // R5/R8: rising sets event and raises irq
        step(32'h0004_0000, 1'b0, 2'd0, 32'h0, "R5 R8 rise");
        // R5: falling clears event, irq stays
        step(32'h0, 1'b0, 2'd0, 32'h0, "R5 R8 fall");
        // R9: clear write with nothing pending releases
        step(32'h0, 1'b1, 2'd3, 32'h0, "R9 release");
        step(32'h0000_0009, 1'b0, 2'd0, 32'h0, "R5 two rises");
        step(32'h0000_0009, 1'b1, 2'd3, 32'h0000_0001, "R9 partial clear");
        // R7: bit 31 in edge mode has no effect
        step(32'h0000_0009, 1'b1, 2'd3, 32'h8000_0000, "R7 bit31 edge mode");
        // R2: writes to read-only registers ignored
        step(32'h0000_0009, 1'b1, 2'd1, 32'h0, "R2 events write");
        step(32'h0000_0009, 1'b1, 2'd2, 32'hFFFF_FFFF, "R2 levels write");
        step(32'h0000_0009, 1'b1, 2'd3, 32'h0000_0008, "R9 clear last");
        // R6: disabled source
        step(32'h0000_0009, 1'b1, 2'd0, 32'h0000_00F0, "R6 enable");
        step(32'h0000_0129, 1'b0, 2'd0, 32'h0, "R6 gate");
        // R4: any-change mode
        step(32'h0000_0129, 1'b1, 2'd0, 32'hFFFF_FFFF, "R4 enable");
        step(32'h8000_0128, 1'b0, 2'd0, 32'h0, "R4 toggles");
        step(32'h8000_0128, 1'b1, 2'd3, 32'h8000_0000, "R7 wipe");
        // R10: clear and new event same cycle
        step(32'h0000_0128, 1'b1, 2'd3, 32'h8000_0000, "R10 same cycle");
        step(32'h0000_0128, 1'b1, 2'd3, 32'h0000_0000, "R9 no-op clear");
        step(32'h0000_0128, 1'b1, 2'd3, 32'h8000_0000, "R7 R9 wipe release");

        // sweep: pseudo-random lines and bus operations
        lfsr = 32'hACE1_2357;
        ln = 32'h0000_0128;
        for (int i = 0; i < SWEEP_STEPS; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            if (lfsr[3:2] != 2'b00) ln = ln ^ (32'h1 << lfsr[8:4]) ^ ((lfsr[9]) ? (32'h1 << lfsr[14:10]) : 32'h0);
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(ln, lfsr[0] & lfsr[1], lfsr[5:4], {lfsr[31], lfsr[30:0] ^ {lfsr[15:0], lfsr[30:16]}},
                 "SWEEP R3 R4 R5 R6 R7 R8 R9 R10");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule